// File: doc/BRIEF.md
# Flash Status Register Controller

This block holds the status byte of a byte-wide NOR flash that runs its program and erase jobs on an internal state machine. It also owns the read mode of the device. Command bytes arrive on a one-cycle write strobe. A simple algorithm engine reports its progress through single-cycle event pulses: job started, job finished, write failed, erase failed, suspended and resumed. The block answers with one-cycle requests to start a job, suspend an erase or resume an erase.

A read happens while both active-low enables are low. In status mode the read returns the status byte, and that byte is held for as long as the read stays active. In array mode the read returns a placeholder array byte taken from an input. The controller enters status mode on its own whenever a job is confirmed, suspended or resumed. Error flags stay set until software clears them. While any error flag is set, the block refuses new write and erase jobs and lowers `op_allow`.

Top module: `flash_status_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, the status byte becomes 80h, the block enters array mode and pending setups are dropped. After reset, `op_allow` is 1.
- R2: Command 70h selects status mode. A read in status mode returns {ready, suspended, erase error, write error, voltage error, 3'b000}, with bit 7 as ready and bits 2:0 always 0.
- R3: Command FFh selects array mode only when the engine is ready and not suspended. In array mode `dq_o` follows `array_byte` while a read is active.
- R4: Setup 40h followed by any byte, or setup 20h followed by D0h, raises `op_req` for one cycle after the second strobe. `op_erase` is 0 for a write and 1 for an erase. The block then enters status mode. Setups are accepted only when the engine is ready, not suspended and no error flag is set.
- R5: `eng_start` clears status bit 7 (busy). `eng_done` sets it again (ready).
- R6: `eng_wr_fail` sets bit 4 and `eng_er_fail` sets bit 5. Both stay set through later commands and reads until a clear or a reset.
- R7: `vpp_low` is sampled only on an accepted confirm. If it is high there, bit 3 is set and no `op_req` is raised. At any other time it has no effect.
- R8: While any of bits 5:3 is set, `op_allow` is 0 and setup commands 40h and 20h are ignored, so no `op_req` follows them.
- R9: Command 50h, given outside a pending setup, clears bits 5:3 and leaves bits 7:6 unchanged.
- R10: Command B0h during a busy erase raises `susp_req` for one cycle. `eng_susp` sets bits 7 and 6. D0h while suspended raises `resume_req`. `eng_resume` clears bits 6 and 7.
- R11: During a continuous read in status mode, `dq_o` stays frozen at the value captured when the read began. A new status value appears only after `ce_n` or `oe_n` has toggled.
- R12: `dq_oe` is 1 exactly while `ce_n` and `oe_n` are both low. At all other times `dq_o` is 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset pin, sampled synchronously |
| cmd_we | input | 1 | One-cycle command strobe |
| cmd_byte | input | 8 | Command or data byte |
| ce_n | input | 1 | Active-low chip enable |
| oe_n | input | 1 | Active-low output enable |
| array_byte | input | 8 | Placeholder array data |
| eng_start | input | 1 | Engine began a job |
| eng_done | input | 1 | Engine finished a job |
| eng_wr_fail | input | 1 | Write verify ran out of retries |
| eng_er_fail | input | 1 | Erase verify ran out of retries |
| eng_susp | input | 1 | Erase suspend took effect |
| eng_resume | input | 1 | Erase resume accepted |
| vpp_low | input | 1 | Programming voltage missing |
| op_allow | output | 1 | New write/erase jobs permitted |
| op_req | output | 1 | One-cycle job start request |
| op_erase | output | 1 | Requested job is an erase |
| susp_req | output | 1 | One-cycle erase suspend request |
| resume_req | output | 1 | One-cycle erase resume request |
| dq_o | output | 8 | Read data |
| dq_oe | output | 1 | Read data valid |

## Verification
The bench builds the block with its default command codes. With the real byte values in place, commands that a setup swallows as data and confirm bytes given outside a setup can both be driven. Sticky flags are carried through ignored write and erase attempts. A read is held open while the engine finishes, which shows that the output stays frozen until an enable toggles. The voltage flag is driven both at confirm and between jobs, so sampling can be told apart from continuous monitoring.

// File: rtl/flash_status_ctrl.sv
module flash_status_ctrl #(
  parameter logic [7:0] CMD_STATUS  = 8'h70,
  parameter logic [7:0] CMD_CLEAR   = 8'h50,
  parameter logic [7:0] CMD_SUSPEND = 8'hB0,
  parameter logic [7:0] CMD_CONFIRM = 8'hD0,
  parameter logic [7:0] CMD_ARRAY   = 8'hFF,
  parameter logic [7:0] CMD_WRITE   = 8'h40,
  parameter logic [7:0] CMD_ERASE   = 8'h20
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_we,
  input  logic [7:0] cmd_byte,
  input  logic       ce_n,
  input  logic       oe_n,
  input  logic [7:0] array_byte,
  input  logic       eng_start,
  input  logic       eng_done,
  input  logic       eng_wr_fail,
  input  logic       eng_er_fail,
  input  logic       eng_susp,
  input  logic       eng_resume,
  input  logic       vpp_low,
  output logic       op_allow,
  output logic       op_req,
  output logic       op_erase,
  output logic       susp_req,
  output logic       resume_req,
  output logic [7:0] dq_o,
  output logic       dq_oe
);

  logic rdy, susp, e_err, w_err, v_err;
  logic st_mode, pend_wr, pend_er, eact;
  logic [7:0] lat;

  wire [7:0] status = {rdy, susp, e_err, w_err, v_err, 3'b000};
  wire rd = ~ce_n & ~oe_n;
  wire idle = rdy & ~susp;
  wire pend = pend_wr | pend_er;

  assign op_allow = ~(e_err | w_err | v_err);
  assign dq_oe = rd;
  assign dq_o = rd ? (st_mode ? lat : array_byte) : 8'h00;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdy <= 1'b1; susp <= 1'b0;
      e_err <= 1'b0; w_err <= 1'b0; v_err <= 1'b0;
      st_mode <= 1'b0; pend_wr <= 1'b0; pend_er <= 1'b0; eact <= 1'b0;
      op_req <= 1'b0; op_erase <= 1'b0; susp_req <= 1'b0; resume_req <= 1'b0;
      lat <= 8'h80;
    end else begin
      op_req <= 1'b0;
      susp_req <= 1'b0;
      resume_req <= 1'b0;
      if (!rd) lat <= status;
      if (cmd_we) begin
        if (pend) begin
          pend_wr <= 1'b0;
          pend_er <= 1'b0;
          st_mode <= 1'b1;
          if ((pend_wr || cmd_byte == CMD_CONFIRM) && op_allow) begin
            if (vpp_low) v_err <= 1'b1;
            else begin
              op_req <= 1'b1;
              op_erase <= pend_er;
              eact <= pend_er;
            end
          end
        end else begin
          case (cmd_byte)
            CMD_STATUS:  st_mode <= 1'b1;
            CMD_ARRAY:   if (idle) st_mode <= 1'b0;
            CMD_CLEAR:   begin e_err <= 1'b0; w_err <= 1'b0; v_err <= 1'b0; end
            CMD_WRITE:   if (idle && op_allow) pend_wr <= 1'b1;
            CMD_ERASE:   if (idle && op_allow) pend_er <= 1'b1;
            CMD_SUSPEND: if (!rdy && eact && !susp) begin susp_req <= 1'b1; st_mode <= 1'b1; end
            CMD_CONFIRM: if (susp) begin resume_req <= 1'b1; st_mode <= 1'b1; end
            default: ;
          endcase
        end
      end
      if (eng_start) rdy <= 1'b0;
      if (eng_done) begin rdy <= 1'b1; eact <= 1'b0; end
      if (eng_susp) begin rdy <= 1'b1; susp <= 1'b1; end
      if (eng_resume) begin rdy <= 1'b0; susp <= 1'b0; end
      if (eng_wr_fail) w_err <= 1'b1;
      if (eng_er_fail) e_err <= 1'b1;
    end
  end

  // R5
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_start && !eng_done && !eng_susp) |=> !status[7]);

  // R8
  lockout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !op_allow |=> !op_req);

  // R11
  read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && $past(rd) && st_mode && $past(st_mode)) |-> $stable(dq_o));

  // R6
  sticky_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (w_err && !(cmd_we && cmd_byte == CMD_CLEAR && !pend)) |=> w_err);

  // R10
  suspend_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_susp && !eng_resume && !eng_start) |=> (status[7] && status[6]));

  // R9
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && cmd_byte == CMD_CLEAR && !pend && !eng_wr_fail && !eng_er_fail)
      |=> (status[5:3] == 3'b000));

endmodule

// File: tb/sim_flash_status_ctrl.sv
module sim_flash_status_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_we = 1'b0;
  logic [7:0] cmd_byte = 8'h00;
  logic ce_n = 1'b1, oe_n = 1'b1;
  logic [7:0] array_byte = 8'h5A;
  logic eng_start = 0, eng_done = 0, eng_wr_fail = 0, eng_er_fail = 0;
  logic eng_susp = 0, eng_resume = 0, vpp_low = 0;
  logic op_allow, op_req, op_erase, susp_req, resume_req, dq_oe;
  logic [7:0] dq_o;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  flash_status_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_byte(cmd_byte),
    .ce_n(ce_n), .oe_n(oe_n), .array_byte(array_byte),
    .eng_start(eng_start), .eng_done(eng_done), .eng_wr_fail(eng_wr_fail),
    .eng_er_fail(eng_er_fail), .eng_susp(eng_susp), .eng_resume(eng_resume),
    .vpp_low(vpp_low), .op_allow(op_allow), .op_req(op_req), .op_erase(op_erase),
    .susp_req(susp_req), .resume_req(resume_req), .dq_o(dq_o), .dq_oe(dq_oe));

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cmd(input logic [7:0] b);
    @(negedge clk); cmd_we = 1'b1; cmd_byte = b;
    @(negedge clk); cmd_we = 1'b0;
  endtask

  task automatic ev(input int k);
    @(negedge clk);
    case (k)
      0: eng_start = 1'b1;
      1: eng_done = 1'b1;
      2: eng_wr_fail = 1'b1;
      3: eng_er_fail = 1'b1;
      4: eng_susp = 1'b1;
      default: eng_resume = 1'b1;
    endcase
    @(negedge clk);
    {eng_start, eng_done, eng_wr_fail, eng_er_fail, eng_susp, eng_resume} = '0;
  endtask

  task automatic rd_byte(output logic [7:0] v);
    @(negedge clk); ce_n = 1'b1; oe_n = 1'b1;
    @(negedge clk); ce_n = 1'b0; oe_n = 1'b0;
    #1 v = dq_o;
    @(negedge clk); ce_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    rd_byte(v); chk(v, 8'h5A, "R1 array mode after reset");
    chk(op_allow, 1, "R1 op_allow");
    cmd(8'h70); rd_byte(v); chk(v, 8'h80, "R1 R2 status after reset");
  endtask

  task automatic t_write;
    logic [7:0] v;
    cmd(8'h40); cmd(8'h33);
    chk(op_req, 1, "R4 write op_req"); chk(op_erase, 0, "R4 write op_erase");
    @(negedge clk); chk(op_req, 0, "R4 op_req one cycle");
    ev(0); rd_byte(v); chk(v, 8'h00, "R5 busy");
    ev(1); rd_byte(v); chk(v, 8'h80, "R5 ready");
    chk(v & 8'h07, 8'h00, "R2 reserved bits");
  endtask

  task automatic t_erase;
    logic [7:0] v;
    cmd(8'h20); cmd(8'hD0);
    chk(op_req, 1, "R4 erase op_req"); chk(op_erase, 1, "R4 erase op_erase");
    ev(0); cmd(8'hB0); chk(susp_req, 1, "R10 susp_req");
    ev(4); rd_byte(v); chk(v, 8'hC0, "R10 suspended status");
    cmd(8'hD0); chk(resume_req, 1, "R10 resume_req");
    ev(5); rd_byte(v); chk(v, 8'h00, "R10 resumed busy");
    ev(1); rd_byte(v); chk(v, 8'h80, "R5 erase done");
  endtask

  task automatic t_sticky;
    logic [7:0] v;
    cmd(8'h40); cmd(8'h01); ev(0); ev(2); ev(1);
    rd_byte(v); chk(v, 8'h90, "R6 write error set");
    chk(op_allow, 0, "R8 op_allow low");
    cmd(8'h40); chk(op_req, 0, "R8 setup ignored");
    cmd(8'h02); chk(op_req, 0, "R8 no job");
    cmd(8'h20); cmd(8'hD0); chk(op_req, 0, "R8 erase ignored");
    rd_byte(v); chk(v, 8'h90, "R6 retained after attempts");
    ev(3); rd_byte(v); chk(v, 8'hB0, "R6 erase error added");
    cmd(8'h50); rd_byte(v); chk(v, 8'h80, "R9 cleared");
    chk(op_allow, 1, "R9 op_allow back");
    cmd(8'h40); cmd(8'hAA); chk(op_req, 1, "R9 write accepted after clear");
    ev(0); ev(1);
  endtask

  task automatic t_vpp;
    logic [7:0] v;
    vpp_low = 1'b1;
    rd_byte(v); chk(v, 8'h80, "R7 not monitored when idle");
    cmd(8'h40); cmd(8'h05); chk(op_req, 0, "R7 no job on low voltage");
    rd_byte(v); chk(v, 8'h88, "R7 voltage flag");
    chk(op_allow, 0, "R8 voltage lockout");
    vpp_low = 1'b0;
    rd_byte(v); chk(v, 8'h88, "R7 flag stays");
    cmd(8'h50); rd_byte(v); chk(v, 8'h80, "R9 voltage flag cleared");
  endtask

  task automatic t_latch;
    logic [7:0] v;
    ev(0);
    @(negedge clk); ce_n = 1'b0; oe_n = 1'b0;
    @(negedge clk); chk(dq_o, 8'h00, "R11 busy read");
    ev(1); @(negedge clk); chk(dq_o, 8'h00, "R11 frozen while held");
    oe_n = 1'b1; @(negedge clk); oe_n = 1'b0; #1;
    chk(dq_o, 8'h80, "R11 refreshed after toggle");
    @(negedge clk); ce_n = 1'b1; oe_n = 1'b1; #1;
    chk(dq_oe, 0, "R12 oe low"); chk(dq_o, 8'h00, "R12 bus idle");
    ev(0); cmd(8'hFF); rd_byte(v); chk(v, 8'h00, "R3 array ignored while busy");
    ev(1); cmd(8'hFF);
    array_byte = 8'h3C; rd_byte(v); chk(v, 8'h3C, "R3 array read");
    @(negedge clk); ce_n = 1'b0; oe_n = 1'b0; array_byte = 8'hC3; #1;
    chk(dq_o, 8'hC3, "R3 array follows"); chk(dq_oe, 1, "R12 oe high");
    @(negedge clk); ce_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic t_rst_mid;
    logic [7:0] v;
    cmd(8'h40); cmd(8'h07); ev(0); ev(2);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
    array_byte = 8'h66; rd_byte(v); chk(v, 8'h66, "R1 array after reset");
    chk(op_allow, 1, "R1 errors cleared");
    cmd(8'h70); rd_byte(v); chk(v, 8'h80, "R1 ready after reset");
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_write();
    t_erase();
    t_sticky();
    t_vpp();
    t_latch();
    t_rst_mid();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule